// File: doc/BRIEF.md
# RF Bus Trigger Scheduler

This block decides when the serial RF control bus should send a word. It watches a free-running quarter-bit counter that counts from 0 to 4999 in each frame. It compares that count with the programmed start positions of the receive (RX), transmit (TX) and monitor (MON) bursts. From those matches it raises three kinds of single-cycle trigger pulse:

- a frequency/gain trigger, raised at each burst start;
- a DAC-on gain trigger, raised ahead of each burst start by an amount that depends on the AGC lead setting;
- a DAC-off gain trigger, raised after each receive burst ends.

Each pulse carries a 2-bit tag that tells the bus shifter which source's payload to send.

The bus must stay quiet while a burst is on air. A trigger that comes due during a burst is therefore parked in a pending slot for its channel. Parked triggers are released one per cycle in a fixed priority once the burst-active input drops. The register file and the serial shifter sit outside this block.

Top module: `rf_trig_sched`

## Requirements
- R1: When `qb_cnt_i` equals the RX, TX or MON start value, `fg_trig_o` pulses for one cycle in the following clock cycle. `fg_tag_o` then carries the source: RX=1, TX=2, MON=3. Every tag output reads 0 in any cycle where its pulse is low.
- R2: The DAC-on trigger pulses one cycle after `qb_cnt_i` equals `(start + 1024 - 32*agc_start_i) mod 5000` for a source, and its tag names that source. The target wraps past the frame end.
- R3: A DAC-off trigger pulses one cycle after the first cycle in which `burst_active_i` is low following a cycle in which it was high. This happens only if the burst's `burst_tag_i` was RX (1) or MON (3). The DAC-off tag equals that burst tag. The end of a TX burst produces no DAC-off trigger.
- R4: No trigger output pulses in the cycle after a cycle in which `burst_active_i` is high. Triggers that come due then are deferred, not lost.
- R5: When several triggers are due in a cycle with no burst active, one is issued per cycle in the priority DAC-off, then DAC-on, then frequency. The others follow in later cycles.
- R6: At most one of the three trigger outputs pulses in any cycle.
- R7: When several sources match the same channel in one cycle, the tag takes the highest-priority source: RX, then TX, then MON.
- R8: While a channel holds a deferred trigger, further events for that channel are discarded until the held trigger is issued.
- R9: While `rst_ni` is low, all trigger outputs and tags are 0 and no deferred trigger survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qb_cnt_i | input | 13 | Quarter-bit counter, 0..4999 |
| rx_start_i | input | 13 | RX burst start position |
| tx_start_i | input | 13 | TX burst start position |
| mon_start_i | input | 13 | MON burst start position |
| agc_start_i | input | 5 | AGC lead setting, in steps of 32 quarter-bits |
| burst_active_i | input | 1 | A burst is currently on air |
| burst_tag_i | input | 2 | Kind of the active burst (RX=1, TX=2, MON=3) |
| fg_trig_o | output | 1 | Frequency/gain trigger pulse |
| fg_tag_o | output | 2 | Source of the frequency/gain trigger |
| dac_on_trig_o | output | 1 | DAC-on gain trigger pulse |
| dac_on_tag_o | output | 2 | Source of the DAC-on trigger |
| dac_off_trig_o | output | 1 | DAC-off gain trigger pulse |
| dac_off_tag_o | output | 2 | Burst kind that ended |

## Verification
The assertions check four rules on every cycle:

- the bus is silent in the cycle after a burst-active cycle;
- the three pulses are mutually exclusive;
- a receive burst's end is always followed at once by a DAC-off pulse carrying a receive tag;
- a pulse never carries the empty tag.

Other behaviour only the bench scenarios can show: that a deferred trigger comes out later with the right tag, the release order after a burst, the discarding of a second event for an occupied channel, the wrapped DAC-on target, and the choice among sources that match together.

// File: rtl/rfts_pkg.sv
package rfts_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2,
    SRC_MON  = 2'd3
  } src_e;

  typedef struct packed {
    logic vld;
    src_e src;
  } trig_t;

  localparam int N_SRC  = 3;
  // channel index doubles as release priority (lowest first)
  localparam int N_CH   = 3;
  localparam int CH_OFF = 0;
  localparam int CH_ON  = 1;
  localparam int CH_FG  = 2;
endpackage

// File: rtl/rfts_match.sv
module rfts_match
  import rfts_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int AGC_W     = 5,
  parameter int FRAME_LEN = 5000,
  parameter int LEAD      = 1024,
  parameter int STEP      = 32
) (
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [N_SRC-1:0][CNT_W-1:0] start_i,
  input  logic [AGC_W-1:0]            agc_i,
  output trig_t                       fg_ev_o,
  output trig_t                       on_ev_o
);
  localparam int SUM_W = CNT_W + 2;

  logic [N_SRC-1:0] fg_hit, on_hit;
  logic [SUM_W-1:0] lead_amt;

  assign lead_amt = SUM_W'(LEAD) - SUM_W'(agc_i) * SUM_W'(STEP);

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [SUM_W-1:0] raw, tgt;
    assign raw = SUM_W'(start_i[s]) + lead_amt;
    assign tgt = (raw >= SUM_W'(FRAME_LEN)) ? raw - SUM_W'(FRAME_LEN) : raw;
    assign fg_hit[s] = (cnt_i == start_i[s]);
    assign on_hit[s] = (SUM_W'(cnt_i) == tgt);
  end

  // lowest source index wins the tag
  always_comb begin
    fg_ev_o = '0;
    on_ev_o = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (fg_hit[s]) fg_ev_o = '{vld: 1'b1, src: src_e'(s + 1)};
      if (on_hit[s]) on_ev_o = '{vld: 1'b1, src: src_e'(s + 1)};
    end
  end
endmodule

// File: rtl/rfts_burst_mon.sv
module rfts_burst_mon
  import rfts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       burst_i,
  input  logic [1:0] tag_i,
  output trig_t      off_ev_o
);
  logic burst_q;
  src_e tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      tag_q   <= SRC_NONE;
    end else begin
      burst_q <= burst_i;
      if (burst_i) tag_q <= src_e'(tag_i);
    end
  end

  always_comb begin
    off_ev_o = '0;
    if (burst_q && !burst_i && (tag_q == SRC_RX || tag_q == SRC_MON))
      off_ev_o = '{vld: 1'b1, src: tag_q};
  end
endmodule

// File: rtl/rfts_arb.sv
module rfts_arb
  import rfts_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_i,
  input  trig_t [N_CH-1:0]     ev_i,
  output trig_t [N_CH-1:0]     trig_o
);
  trig_t [N_CH-1:0] pend_q, cand, pend_d, out_d;
  logic             found;

  always_comb begin
    found  = 1'b0;
    out_d  = '0;
    for (int c = 0; c < N_CH; c++) begin
      cand[c]   = pend_q[c].vld ? pend_q[c] : ev_i[c];
      pend_d[c] = cand[c];
      if (!hold_i && !found && cand[c].vld) begin
        found     = 1'b1;
        out_d[c]  = cand[c];
        pend_d[c] = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      trig_o <= '0;
    end else begin
      pend_q <= pend_d;
      trig_o <= out_d;
    end
  end
endmodule

// File: rtl/rf_trig_sched.sv
module rf_trig_sched
  import rfts_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int AGC_W     = 5,
  parameter int FRAME_LEN = 5000,
  parameter int LEAD      = 1024,
  parameter int STEP      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] qb_cnt_i,
  input  logic [CNT_W-1:0] rx_start_i,
  input  logic [CNT_W-1:0] tx_start_i,
  input  logic [CNT_W-1:0] mon_start_i,
  input  logic [AGC_W-1:0] agc_start_i,
  input  logic             burst_active_i,
  input  logic [1:0]       burst_tag_i,
  output logic             fg_trig_o,
  output logic [1:0]       fg_tag_o,
  output logic             dac_on_trig_o,
  output logic [1:0]       dac_on_tag_o,
  output logic             dac_off_trig_o,
  output logic [1:0]       dac_off_tag_o
);
  logic [N_SRC-1:0][CNT_W-1:0] starts;
  trig_t                       fg_ev, on_ev, off_ev;
  trig_t [N_CH-1:0]            ev, trig;

  assign starts = {mon_start_i, tx_start_i, rx_start_i};

  rfts_match #(
    .CNT_W(CNT_W), .AGC_W(AGC_W), .FRAME_LEN(FRAME_LEN), .LEAD(LEAD), .STEP(STEP)
  ) u_match (
    .cnt_i   (qb_cnt_i),
    .start_i (starts),
    .agc_i   (agc_start_i),
    .fg_ev_o (fg_ev),
    .on_ev_o (on_ev)
  );

  rfts_burst_mon u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .burst_i  (burst_active_i),
    .tag_i    (burst_tag_i),
    .off_ev_o (off_ev)
  );

  always_comb begin
    ev         = '0;
    ev[CH_OFF] = off_ev;
    ev[CH_ON]  = on_ev;
    ev[CH_FG]  = fg_ev;
  end

  rfts_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (burst_active_i),
    .ev_i   (ev),
    .trig_o (trig)
  );

  assign fg_trig_o      = trig[CH_FG].vld;
  assign fg_tag_o       = trig[CH_FG].src;
  assign dac_on_trig_o  = trig[CH_ON].vld;
  assign dac_on_tag_o   = trig[CH_ON].src;
  assign dac_off_trig_o = trig[CH_OFF].vld;
  assign dac_off_tag_o  = trig[CH_OFF].src;
endmodule

// File: rtl/rfts_chk.sv
module rfts_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       burst_active_i,
  input logic [1:0] burst_tag_i,
  input logic       fg_trig_o,
  input logic [1:0] fg_tag_o,
  input logic       dac_on_trig_o,
  input logic [1:0] dac_on_tag_o,
  input logic       dac_off_trig_o,
  input logic [1:0] dac_off_tag_o
);
  logic       prev_b;
  logic [1:0] prev_t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_b <= 1'b0;
      prev_t <= 2'd0;
    end else begin
      prev_b <= burst_active_i;
      prev_t <= burst_tag_i;
    end
  end

  p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fg_trig_o, dac_on_trig_o, dac_off_trig_o}));

  p_quiet_in_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_active_i |=> !(fg_trig_o || dac_on_trig_o || dac_off_trig_o));

  p_off_after_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_b && !burst_active_i && (prev_t == 2'd1 || prev_t == 2'd3))
      |=> (dac_off_trig_o && dac_off_tag_o == $past(prev_t)));

  p_off_tag_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_off_trig_o |-> (dac_off_tag_o == 2'd1 || dac_off_tag_o == 2'd3));

  p_fg_tag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fg_trig_o |-> fg_tag_o != 2'd0);

  p_on_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_on_trig_o |-> dac_on_tag_o != 2'd0);
endmodule

bind rf_trig_sched rfts_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .burst_active_i (burst_active_i),
  .burst_tag_i    (burst_tag_i),
  .fg_trig_o      (fg_trig_o),
  .fg_tag_o       (fg_tag_o),
  .dac_on_trig_o  (dac_on_trig_o),
  .dac_on_tag_o   (dac_on_tag_o),
  .dac_off_trig_o (dac_off_trig_o),
  .dac_off_tag_o  (dac_off_tag_o)
);

// File: tb/tb_rf_trig_sched.sv
`timescale 1ns/1ps
module tb_rf_trig_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cnt = '0, rx_s = '0, tx_s = '0, mon_s = '0;
  logic [4:0]  agc = '0;
  logic        burst = 1'b0;
  logic [1:0]  btag = '0;
  logic        fg, on, off;
  logic [1:0]  fg_t, on_t, off_t;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rf_trig_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .qb_cnt_i(cnt),
    .rx_start_i(rx_s), .tx_start_i(tx_s), .mon_start_i(mon_s),
    .agc_start_i(agc), .burst_active_i(burst), .burst_tag_i(btag),
    .fg_trig_o(fg), .fg_tag_o(fg_t),
    .dac_on_trig_o(on), .dac_on_tag_o(on_t),
    .dac_off_trig_o(off), .dac_off_tag_o(off_t)
  );

  // behavioural reference: index 0 = DAC-off, 1 = DAC-on, 2 = frequency
  int pend_v[3], pend_t[3], e_v[3], e_t[3];
  int prev_b, prev_t;

  always @(posedge clk or negedge rst_n) begin
    int ev_v[3], ev_t[3], cv[3], ct[3], st[3];
    int g, tgt;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        pend_v[k] = 0; pend_t[k] = 0; e_v[k] = 0; e_t[k] = 0;
      end
      prev_b = 0; prev_t = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin ev_v[k] = 0; ev_t[k] = 0; end
      if (prev_b != 0 && !burst && (prev_t == 1 || prev_t == 3)) begin
        ev_v[0] = 1; ev_t[0] = prev_t;
      end
      st[0] = int'(rx_s); st[1] = int'(tx_s); st[2] = int'(mon_s);
      for (int i = 0; i < 3; i++) begin
        tgt = (st[i] + 1024 - 32 * int'(agc)) % 5000;
        if (ev_v[2] == 0 && int'(cnt) == st[i]) begin ev_v[2] = 1; ev_t[2] = i + 1; end
        if (ev_v[1] == 0 && int'(cnt) == tgt)   begin ev_v[1] = 1; ev_t[1] = i + 1; end
      end
      g = -1;
      for (int k = 0; k < 3; k++) begin
        cv[k] = pend_v[k] != 0 ? 1 : ev_v[k];
        ct[k] = pend_v[k] != 0 ? pend_t[k] : ev_t[k];
        if (!burst && g < 0 && cv[k] != 0) g = k;
      end
      for (int k = 0; k < 3; k++) begin
        e_v[k]    = (k == g) ? 1 : 0;
        e_t[k]    = (k == g) ? ct[k] : 0;
        pend_v[k] = (cv[k] != 0 && k != g) ? 1 : 0;
        pend_t[k] = pend_v[k] != 0 ? ct[k] : 0;
      end
      prev_b = int'(burst); prev_t = int'(btag);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(off) != e_v[0] || int'(off_t) != e_t[0]) begin
        n_fail++;
        $display("FAIL R3 model dac_off act=%0d/%0d exp=%0d/%0d", off, off_t, e_v[0], e_t[0]);
      end
      if (int'(on) != e_v[1] || int'(on_t) != e_t[1]) begin
        n_fail++;
        $display("FAIL R2 model dac_on act=%0d/%0d exp=%0d/%0d", on, on_t, e_v[1], e_t[1]);
      end
      if (int'(fg) != e_v[2] || int'(fg_t) != e_t[2]) begin
        n_fail++;
        $display("FAIL R1 model fg act=%0d/%0d exp=%0d/%0d", fg, fg_t, e_v[2], e_t[2]);
      end
      if (int'(fg) + int'(on) + int'(off) > 1) begin
        n_fail++;
        $display("FAIL R6 pulses act=%0d exp<=1", int'(fg) + int'(on) + int'(off));
      end
    end
  end

  task automatic cyc(int c, bit b, int t);
    cnt = 13'(c); burst = b; btag = 2'(t);
    @(negedge clk);
  endtask

  task automatic expect_out(string req, int xfg, int xfgt, int xon, int xont, int xoff, int xofft);
    n_chk++;
    if (int'(fg) != xfg || int'(fg_t) != xfgt || int'(on) != xon || int'(on_t) != xont ||
        int'(off) != xoff || int'(off_t) != xofft) begin
      n_fail++;
      $display("FAIL %s act fg=%0d/%0d on=%0d/%0d off=%0d/%0d exp fg=%0d/%0d on=%0d/%0d off=%0d/%0d",
               req, fg, fg_t, on, on_t, off, off_t, xfg, xfgt, xon, xont, xoff, xofft);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rx_s = 13'd100; tx_s = 13'd2000; mon_s = 13'd3000; agc = 5'd4;
    cnt = 13'd100; burst = 1'b1; btag = 2'd1;
    repeat (3) @(negedge clk);
    expect_out("R9 reset", 0, 0, 0, 0, 0, 0);
    burst = 1'b0; btag = 2'd0; cnt = 13'd0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 0);     expect_out("R9 after reset", 0, 0, 0, 0, 0, 0);

    // R1 / R2 basic matches; DAC-on lead = 1024 - 128 = 896
    cyc(100, 0, 0);   expect_out("R1 rx start", 1, 1, 0, 0, 0, 0);
    cyc(101, 0, 0);   expect_out("R1 single pulse", 0, 0, 0, 0, 0, 0);
    cyc(996, 0, 0);   expect_out("R2 rx dac_on", 0, 0, 1, 1, 0, 0);
    cyc(2000, 0, 0);  expect_out("R1 tx start", 1, 2, 0, 0, 0, 0);
    cyc(2896, 0, 0);  expect_out("R2 tx dac_on", 0, 0, 1, 2, 0, 0);

    // R7 two sources matching together
    rx_s = 13'd700; tx_s = 13'd700;
    cyc(700, 0, 0);   expect_out("R7 fg rx over tx", 1, 1, 0, 0, 0, 0);
    cyc(1596, 0, 0);  expect_out("R7 on rx over tx", 0, 0, 1, 1, 0, 0);
    rx_s = 13'd100; tx_s = 13'd2000;

    // R2 wrap: 4500 + 1024 = 5524 -> 524
    mon_s = 13'd4500; agc = 5'd0;
    cyc(524, 0, 0);   expect_out("R2 wrapped dac_on", 0, 0, 1, 3, 0, 0);
    cyc(4500, 0, 0);  expect_out("R1 mon start", 1, 3, 0, 0, 0, 0);
    mon_s = 13'd3000; agc = 5'd4;

    // R4 trigger on the last cycle of an RX burst
    for (int c = 95; c < 100; c++) cyc(c, 1, 1);
    cyc(100, 1, 1);   expect_out("R4 deferred in burst", 0, 0, 0, 0, 0, 0);
    cyc(101, 0, 0);   expect_out("R3 rx burst end", 0, 0, 0, 0, 1, 1);
    cyc(102, 0, 0);   expect_out("R5 fg released", 1, 1, 0, 0, 0, 0);
    cyc(103, 0, 0);   expect_out("R5 nothing left", 0, 0, 0, 0, 0, 0);

    // R5 / R8 two deferred by one MON burst, a third dropped
    rx_s = 13'd1200; tx_s = 13'd307; mon_s = 13'd1202;
    for (int c = 1198; c < 1206; c++) begin
      cyc(c, 1, 3);
      expect_out("R4 quiet in burst", 0, 0, 0, 0, 0, 0);
    end
    cyc(1206, 0, 0);  expect_out("R5 off first", 0, 0, 0, 0, 1, 3);
    cyc(1207, 0, 0);  expect_out("R5 on second", 0, 0, 1, 2, 0, 0);
    cyc(1208, 0, 0);  expect_out("R8 fg keeps first tag", 1, 1, 0, 0, 0, 0);
    cyc(1209, 0, 0);  expect_out("R8 dropped event gone", 0, 0, 0, 0, 0, 0);

    // R3 TX burst end gives no DAC-off
    for (int c = 1500; c < 1503; c++) cyc(c, 1, 2);
    cyc(1503, 0, 0);  expect_out("R3 tx end silent", 0, 0, 0, 0, 0, 0);
    cyc(1504, 0, 0);  expect_out("R3 tx end silent next", 0, 0, 0, 0, 0, 0);

    // R5 collision outside a burst: 4154 + 896 = 5050 -> 50
    rx_s = 13'd50; tx_s = 13'd4154; mon_s = 13'd3000;
    cyc(50, 0, 0);    expect_out("R5 on before fg", 0, 0, 1, 2, 0, 0);
    cyc(51, 0, 0);    expect_out("R5 fg next cycle", 1, 1, 0, 0, 0, 0);

    // free-running frame against the model
    for (int c = 0; c < 5000; c++) begin
      if (c >= 40 && c < 48) cyc(c, 1, 1);
      else if (c >= 3000 && c < 3010) cyc(c, 1, 3);
      else cyc(c, 0, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule